// File: doc/BRIEF.md
# Default Data Access Protection Checker

This block sits beside the load/store stage of a processor core and judges every data access while page-table protection is switched off. Each cycle up to two accesses arrive, one from each of the two address generators. Each access carries its byte address and a write flag. The current privilege mode and the address of the issuing instruction arrive alongside them. A small set of fixed rules decides whether each access is legal. An illegal access has its memory enable withheld in the same cycle, so it never reaches memory.

On the clock edge after a violation, the block raises a one-cycle synchronous exception request with a fixed cause code. On that same edge it latches four things: the offending byte address, a status word (direction, generator and mode), the instruction address to return to, and a syndrome word. Software reads these four values through a small select/read register port. They stay unchanged until a later violation replaces them.

Top module: `dprot_default_chk`

## Requirements
- R1: Any valid access in user mode (`mode_user`=1) to the register region, which is every address at or above 0xFFC00000, is a violation. This holds for both generators and for both reads and writes.
- R2: A generator-1 access to the register region is a violation in supervisor mode as well. A generator-0 access to that region in supervisor mode is legal.
- R3: A generator-1 access to the scratch window 0xFFB00000 through 0xFFB00FFF is a violation in both modes, for reads and writes. Generator-0 accesses to that window are legal. Addresses below 0xFFC00000 and outside the window are legal for both generators.
- R4: `gN_mem_en` equals `gN_vld` for a legal access and is 0 for a violating access, in the same cycle.
- R5: `exc_req` is high for exactly the one cycle that follows each cycle containing a violation. During that cycle `exc_cause` is 0x23; at all other times it is 0.
- R6: Register select 0 returns the exact byte address of the recorded violating access.
- R7: Register select 1 returns the fault status: bit 0 = 1 for a write, bit 1 = 1 for generator 1, bit 2 = 1 for user mode. Bits 31:3 are 0.
- R8: Register select 2 returns the instruction address (`pc_in`) that was presented with the violating access.
- R9: The recorded registers keep their values through any number of cycles without a violation.
- R10: When both generators violate in the same cycle, both enables are withheld and the generator-0 access is the one recorded.
- R11: After reset `exc_req` is 0 and all four readable registers are 0.
- R12: Register select 3 returns the syndrome: bits 5:0 hold the cause 0x23, and bit 8 holds the privilege mode at the fault (0 for supervisor). All other bits are 0. The whole word is 0 before the first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| pc_in | input | 32 | Address of the instruction issuing this cycle's accesses |
| g0_vld | input | 1 | Generator-0 access valid |
| g0_addr | input | 32 | Generator-0 byte address |
| g0_wr | input | 1 | Generator-0 write (1) or read (0) |
| g1_vld | input | 1 | Generator-1 access valid |
| g1_addr | input | 32 | Generator-1 byte address |
| g1_wr | input | 1 | Generator-1 write (1) or read (0) |
| g0_mem_en | output | 1 | Memory enable for the generator-0 access |
| g1_mem_en | output | 1 | Memory enable for the generator-1 access |
| exc_req | output | 1 | One-cycle exception request |
| exc_cause | output | 6 | Cause code while `exc_req` is high, else 0 |
| reg_sel | input | 2 | Register select: 0 address, 1 status, 2 return address, 3 syndrome |
| reg_rdata | output | 32 | Selected register value |

## Verification
On every cycle, the assertions check the following: the blocking of user-mode register accesses and of generator-1 register and scratch accesses; that a request always follows a blocked access and carries cause 0x23; that the recorded mode bit matches the mode of the previous cycle; and that the recorded registers stay stable in cycles without a request. Other behaviour is visible only through the bench's scenarios. This covers the window edges at 0xFFB00FFF, 0xFFB01000 and 0xFFC00000, the generator-0 priority when both generators violate together, and the exact address, status and return values read back through the register port.

// File: rtl/dprot_pkg.sv
package dprot_pkg;

    localparam int AW   = 32;
    localparam int NGEN = 2;
    localparam logic [5:0] CAUSE_PROT = 6'h23;
    localparam int SYND_MODE_BIT = 8;

    typedef enum logic [1:0] {
        RGN_OPEN    = 2'd0,
        RGN_SCRATCH = 2'd1,
        RGN_MMR     = 2'd2
    } rgn_e;

    typedef enum logic [1:0] {
        SEL_FADDR = 2'd0,
        SEL_FSTAT = 2'd1,
        SEL_RETA  = 2'd2,
        SEL_SYND  = 2'd3
    } rsel_e;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [AW-1:0] addr;
    } acc_t;

    typedef struct packed {
        logic user;
        logic gen1;
        logic wr;
    } fstat_t;

    typedef struct packed {
        logic [AW-1:0] faddr;
        fstat_t        fstat;
        logic [AW-1:0] reta;
        logic [AW-1:0] synd;
    } frec_t;

    // Fixed rules with translation disabled.
    function automatic logic rule_hit(rgn_e rgn, logic user, logic is_gen1);
        logic hit;
        hit = 1'b0;
        if (rgn == RGN_MMR && (user || is_gen1))
            hit = 1'b1;
        if (rgn == RGN_SCRATCH && is_gen1)
            hit = 1'b1;
        return hit;
    endfunction

    function automatic logic [AW-1:0] make_synd(logic user);
        logic [AW-1:0] w;
        w = '0;
        w[5:0] = CAUSE_PROT;
        w[SYND_MODE_BIT] = user;
        return w;
    endfunction

endpackage

// File: rtl/dprot_region_dec.sv
module dprot_region_dec
    import dprot_pkg::*;
#(
    parameter logic [AW-1:0] MMR_BASE  = 32'hFFC0_0000,
    parameter logic [AW-1:0] SCR_BASE  = 32'hFFB0_0000,
    parameter int unsigned   SCR_BYTES = 4096
) (
    input  logic [AW-1:0] addr,
    output rgn_e          rgn
);
    localparam logic [AW-1:0] SCR_LAST = SCR_BASE + AW'(SCR_BYTES - 1);

    always_comb begin
        if (addr >= MMR_BASE)
            rgn = RGN_MMR;
        else if (addr >= SCR_BASE && addr <= SCR_LAST)
            rgn = RGN_SCRATCH;
        else
            rgn = RGN_OPEN;
    end
endmodule

// File: rtl/dprot_rule.sv
module dprot_rule
    import dprot_pkg::*;
#(
    parameter int GEN_ID = 0
) (
    input  acc_t acc,
    input  rgn_e rgn,
    input  logic user,
    output logic viol,
    output logic mem_en
);
    localparam logic IS_GEN1 = (GEN_ID == 1);

    always_comb begin
        viol   = acc.vld && rule_hit(rgn, user, IS_GEN1);
        mem_en = acc.vld && !viol;
    end
endmodule

// File: rtl/dprot_capture.sv
module dprot_capture
    import dprot_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  acc_t [NGEN-1:0] acc,
    input  logic [NGEN-1:0] viol,
    input  logic            user,
    input  logic [AW-1:0]   pc,
    output logic            req,
    output frec_t           rec
);
    frec_t nxt;
    logic  any;

    // Lowest-numbered violating generator wins.
    always_comb begin
        nxt = rec;
        any = 1'b0;
        for (int g = NGEN - 1; g >= 0; g--) begin
            if (viol[g]) begin
                any             = 1'b1;
                nxt.faddr       = acc[g].addr;
                nxt.fstat.wr    = acc[g].wr;
                nxt.fstat.gen1  = (g == 1);
                nxt.fstat.user  = user;
                nxt.reta        = pc;
                nxt.synd        = make_synd(user);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
            rec <= '0;
        end else begin
            req <= any;
            rec <= nxt;
        end
    end
endmodule

// File: rtl/dprot_regport.sv
module dprot_regport
    import dprot_pkg::*;
(
    input  frec_t         rec,
    input  logic [1:0]    sel,
    output logic [AW-1:0] rdata
);
    always_comb begin
        unique case (rsel_e'(sel))
            SEL_FADDR: rdata = rec.faddr;
            SEL_FSTAT: rdata = {{(AW-3){1'b0}}, rec.fstat};
            SEL_RETA:  rdata = rec.reta;
            SEL_SYND:  rdata = rec.synd;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dprot_default_chk.sv
module dprot_default_chk
    import dprot_pkg::*;
#(
    parameter logic [31:0] MMR_BASE  = 32'hFFC0_0000,
    parameter logic [31:0] SCR_BASE  = 32'hFFB0_0000,
    parameter int unsigned SCR_BYTES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_user,
    input  logic [31:0] pc_in,
    input  logic        g0_vld,
    input  logic [31:0] g0_addr,
    input  logic        g0_wr,
    input  logic        g1_vld,
    input  logic [31:0] g1_addr,
    input  logic        g1_wr,
    output logic        g0_mem_en,
    output logic        g1_mem_en,
    output logic        exc_req,
    output logic [5:0]  exc_cause,
    input  logic [1:0]  reg_sel,
    output logic [31:0] reg_rdata
);
    acc_t [NGEN-1:0] acc;
    rgn_e [NGEN-1:0] rgn;
    logic [NGEN-1:0] viol;
    logic [NGEN-1:0] men;
    frec_t           rec;

    always_comb begin
        acc[0] = '{vld: g0_vld, wr: g0_wr, addr: g0_addr};
        acc[1] = '{vld: g1_vld, wr: g1_wr, addr: g1_addr};
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_slot
        dprot_region_dec #(
            .MMR_BASE (MMR_BASE),
            .SCR_BASE (SCR_BASE),
            .SCR_BYTES(SCR_BYTES)
        ) u_dec (
            .addr(acc[g].addr),
            .rgn (rgn[g])
        );
        dprot_rule #(.GEN_ID(g)) u_rule (
            .acc   (acc[g]),
            .rgn   (rgn[g]),
            .user  (mode_user),
            .viol  (viol[g]),
            .mem_en(men[g])
        );
    end

    dprot_capture u_cap (
        .clk (clk),
        .rst (rst),
        .acc (acc),
        .viol(viol),
        .user(mode_user),
        .pc  (pc_in),
        .req (exc_req),
        .rec (rec)
    );

    dprot_regport u_rp (
        .rec  (rec),
        .sel  (reg_sel),
        .rdata(reg_rdata)
    );

    assign g0_mem_en = men[0];
    assign g1_mem_en = men[1];
    assign exc_cause = exc_req ? CAUSE_PROT : 6'h00;
endmodule

// File: rtl/dprot_default_chk_sva.sv
module dprot_default_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        mode_user,
    input logic        g0_vld,
    input logic [31:0] g0_addr,
    input logic        g1_vld,
    input logic [31:0] g1_addr,
    input logic        g0_mem_en,
    input logic        g1_mem_en,
    input logic        exc_req,
    input logic [5:0]  exc_cause,
    input dprot_pkg::frec_t rec
);
    p_user_mmr_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_user && g0_vld && g0_addr >= 32'hFFC0_0000) |-> !g0_mem_en);

    p_gen1_mmr_r2: assert property (@(posedge clk) disable iff (rst)
        (g1_vld && g1_addr >= 32'hFFC0_0000) |-> !g1_mem_en);

    p_gen1_scr_r3: assert property (@(posedge clk) disable iff (rst)
        (g1_vld && g1_addr >= 32'hFFB0_0000 && g1_addr <= 32'hFFB0_0FFF) |-> !g1_mem_en);

    p_req_source_r5: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && exc_req |-> $past((g0_vld && !g0_mem_en) || (g1_vld && !g1_mem_en)));

    p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> exc_cause == 6'h23);

    p_mode_flag_r7: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && exc_req |-> rec.fstat.user == $past(mode_user));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && !exc_req |-> $stable(rec));
endmodule

bind dprot_default_chk dprot_default_chk_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .mode_user(mode_user),
    .g0_vld   (g0_vld),
    .g0_addr  (g0_addr),
    .g1_vld   (g1_vld),
    .g1_addr  (g1_addr),
    .g0_mem_en(g0_mem_en),
    .g1_mem_en(g1_mem_en),
    .exc_req  (exc_req),
    .exc_cause(exc_cause),
    .rec      (rec)
);

// File: tb/dprot_default_chk_tb_top.sv
module dprot_default_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_user = 1'b0;
    logic [31:0] pc_in = '0;
    logic        g0_vld = 1'b0, g0_wr = 1'b0, g1_vld = 1'b0, g1_wr = 1'b0;
    logic [31:0] g0_addr = '0, g1_addr = '0;
    logic        g0_mem_en, g1_mem_en, exc_req;
    logic [5:0]  exc_cause;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state (what should be visible after the last edge)
    bit          m_req = 0;
    logic [31:0] m_regs [4] = '{default: 32'h0};

    always #10 clk = ~clk;

    dprot_default_chk dut_i (
        .clk(clk), .rst(rst), .mode_user(mode_user), .pc_in(pc_in),
        .g0_vld(g0_vld), .g0_addr(g0_addr), .g0_wr(g0_wr),
        .g1_vld(g1_vld), .g1_addr(g1_addr), .g1_wr(g1_wr),
        .g0_mem_en(g0_mem_en), .g1_mem_en(g1_mem_en),
        .exc_req(exc_req), .exc_cause(exc_cause),
        .reg_sel(reg_sel), .reg_rdata(reg_rdata)
    );

    function automatic bit bad(int gen, logic [31:0] a, bit user);
        bit mmr, scr;
        mmr = (a >= 32'hFFC0_0000);
        scr = (a >= 32'hFFB0_0000) && (a < 32'hFFB0_1000);
        return (mmr && (user || gen == 1)) || (scr && gen == 1);
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive, check, then advance the reference to the next edge.
    task automatic step(bit u, logic [31:0] pc,
                        bit v0, logic [31:0] a0, bit w0,
                        bit v1, logic [31:0] a1, bit w1);
        bit b0, b1;
        @(posedge clk);
        #5;
        mode_user = u; pc_in = pc;
        g0_vld = v0; g0_addr = a0; g0_wr = w0;
        g1_vld = v1; g1_addr = a1; g1_wr = w1;
        #5;
        b0 = v0 && bad(0, a0, u);
        b1 = v1 && bad(1, a1, u);
        if (!rst) begin
            cmp("R1/R2/R3/R4 g0_mem_en", {31'b0, g0_mem_en}, {31'b0, v0 && !b0});
            cmp("R1/R2/R3/R4 g1_mem_en", {31'b0, g1_mem_en}, {31'b0, v1 && !b1});
            cmp("R5 exc_req", {31'b0, exc_req}, {31'b0, m_req});
            cmp("R5 exc_cause", {26'b0, exc_cause}, m_req ? 32'h23 : 32'h0);
            for (int s = 0; s < 4; s++) begin
                reg_sel = 2'(s);
                #1;
                case (s)
                    0: cmp("R6/R9/R10/R11 fault addr", reg_rdata, m_regs[0]);
                    1: cmp("R7/R9/R10/R11 fault status", reg_rdata, m_regs[1]);
                    2: cmp("R8/R9/R11 return addr", reg_rdata, m_regs[2]);
                    default: cmp("R12/R11 syndrome", reg_rdata, m_regs[3]);
                endcase
            end
        end
        if (rst) begin
            m_req = 0;
            foreach (m_regs[i]) m_regs[i] = 32'h0;
        end else begin
            m_req = b0 || b1;
            if (b0 || b1) begin
                m_regs[0] = b0 ? a0 : a1;
                m_regs[1] = {29'b0, u, !b0, b0 ? w0 : w1};
                m_regs[2] = pc;
                m_regs[3] = {23'b0, u, 2'b0, 6'h23};
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(mode_user, 32'h0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        idle(2);                                                      // R11 reset state
        // Supervisor
        step(0, 32'h1000, 1, 32'hFFE0_0100, 0, 0, 0, 0);              // R2 gen0 legal
        step(0, 32'h1004, 0, 0, 0, 1, 32'hFFE0_0100, 1);              // R2 gen1 write
        step(0, 32'h1008, 0, 0, 0, 1, 32'hFFE0_0104, 0);              // R2 gen1 read
        step(0, 32'h100C, 0, 0, 0, 1, 32'hFFB0_0000, 1);              // R3 scratch write
        step(0, 32'h1010, 0, 0, 0, 1, 32'hFFB0_0004, 0);              // R3/R6 base+4
        step(0, 32'h1014, 1, 32'hFFB0_0008, 1, 0, 0, 0);              // R3 gen0 legal
        step(0, 32'h1018, 0, 0, 0, 1, 32'hFFB0_0FFF, 0);              // R3 last byte
        step(0, 32'h101C, 0, 0, 0, 1, 32'hFFB0_1000, 0);              // R3 just past
        step(0, 32'h1020, 0, 0, 0, 1, 32'hFFBF_FFFF, 1);              // R3 gap legal
        idle(3);                                                      // R9 hold
        // User
        step(1, 32'h2000, 1, 32'hFFE0_0100, 1, 0, 0, 0);              // R1 gen0 write
        step(1, 32'h2004, 1, 32'hFFE0_0104, 0, 0, 0, 0);              // R1 gen0 read
        step(1, 32'h2008, 0, 0, 0, 1, 32'hFFC0_0000, 1);              // R1 boundary
        step(1, 32'h200C, 1, 32'hFFBF_FFFF, 0, 1, 32'h0000_4000, 1);  // R3 legal both
        step(1, 32'h2010, 0, 0, 0, 1, 32'hFFB0_0010, 0);              // R3 user scratch
        step(1, 32'h2014, 1, 32'hFFC0_0040, 0, 1, 32'hFFB0_0020, 1);  // R10 both
        step(1, 32'h2018, 1, 32'h0000_0100, 1, 1, 32'hFFD0_0000, 0);  // R10 only gen1
        step(0, 32'h201C, 0, 32'hFFC0_0000, 1, 0, 32'hFFB0_0000, 1);  // R4 invalid
        idle(4);                                                      // R9 hold
        for (int k = 0; k < 24; k++)
            step(k[0], 32'h3000 + 32'(k) * 4, k[1], 32'hFFB0_0000 + 32'(k) * 32'h0007_1000, k[2],
                 k[3] | k[4], 32'hFFA0_0000 + 32'(k) * 32'h0004_0000, k[0]);
        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule